// File: doc/BRIEF.md
# Foldable Pipeline Stage Chain

This block is a chain of stage registers placed between the stages of a datapath. Each stage can act as a clocked register or as a plain wire that passes its input through within the same cycle. A single mode input switches every odd-numbered stage to the wire form. The chain then has half as many clocked stages, and the datapath between them does not change.

A valid flag travels with each data word along the same path, clocked where the word is clocked and passed through where the word is passed through. Valid and data therefore always arrive together. Software or the system sets the mode while the chain is idle. The chain has no stall and no backpressure: it accepts one word per cycle and delivers one word per cycle.

Top module: `skip_pipe`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the output valid flag is 0 in both modes.
- R2: With the mode input low, a word presented with valid high appears at the output, with valid high and unchanged data, exactly NUM_STAGES clock cycles later.
- R3: With the mode input high, stages 1, 3, 5, … pass their input through in the same cycle and stage 0, 2, 4, … stay clocked. A word therefore appears at the output exactly NUM_STAGES/2 cycles after it enters.
- R4: The valid flag follows the same path as its data. An input cycle with valid low produces an output cycle with valid low after the same latency, and the output never shows valid high without a matching earlier input.
- R5: In either mode, the chain accepts a new word on every cycle. A back-to-back stream comes out complete and in order, one word per cycle.
- R6: After the chain has drained, a change of the mode input takes effect for the next word entered. That word sees the latency of the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low; clears every valid flag |
| halfMode | input | 1 | 1 = odd stages pass through (half latency); change only when the chain is empty |
| inValid | input | 1 | Input word qualifier |
| inData | input | DATA_W | Input word |
| outValid | output | 1 | Output word qualifier |
| outData | output | DATA_W | Output word, meaningful when outValid is 1 |

## Verification
The chain is driven in each mode with three input patterns. A lone word shows the exact latency. A gap-free burst of random words shows full throughput and ordering. An alternating valid/idle pattern shows that bubbles stay in their positions and that idle-cycle data is never reported as valid. The mode is switched both ways after a drain, and the first word after each switch shows that the new latency applies at once. A behavioural history of the inputs, indexed by cycle, gives the expected output on every clock.

// File: rtl/skip_pipe_pkg.sv
package skip_pipe_pkg;

  // Strobes from the mode control to the stage datapath.
  typedef struct packed {
    logic skipOdd;   // odd-indexed stages act as wires
  } stageStrobe_t;

endpackage

// File: rtl/skip_stage_reg.sv
module skip_stage_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              skip,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);

  logic              validQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= inValid;
  end

  // Data needs no reset: it is only looked at under validQ.
  always_ff @(posedge clk) begin
    if (inValid) dataQ <= inData;
  end

  assign outValid = skip ? inValid : validQ;
  assign outData  = skip ? inData  : dataQ;

endmodule

// File: rtl/skip_stage_ctl.sv
module skip_stage_ctl
  import skip_pipe_pkg::*;
(
  input  logic         halfMode,
  output stageStrobe_t strobe
);

  always_comb begin
    strobe         = '0;
    strobe.skipOdd = halfMode;
  end

endmodule

// File: rtl/skip_stage_chain.sv
module skip_stage_chain
  import skip_pipe_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int NUM_STAGES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  stageStrobe_t      strobe,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);

  logic              linkValid [NUM_STAGES+1];
  logic [DATA_W-1:0] linkData  [NUM_STAGES+1];

  assign linkValid[0] = inValid;
  assign linkData[0]  = inData;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : gStage
    logic skipHere;
    if ((i % 2) == 1) begin : gOdd
      assign skipHere = strobe.skipOdd;
    end else begin : gEven
      assign skipHere = 1'b0;
    end

    skip_stage_reg #(.DATA_W(DATA_W)) uStage (
      .clk      (clk),
      .rstN     (rstN),
      .skip     (skipHere),
      .inValid  (linkValid[i]),
      .inData   (linkData[i]),
      .outValid (linkValid[i+1]),
      .outData  (linkData[i+1])
    );
  end

  assign outValid = linkValid[NUM_STAGES];
  assign outData  = linkData[NUM_STAGES];

endmodule

// File: rtl/skip_pipe.sv
module skip_pipe
  import skip_pipe_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int NUM_STAGES = 4   // even, at least 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              halfMode,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);

  stageStrobe_t strobe;

  skip_stage_ctl uCtl (
    .halfMode (halfMode),
    .strobe   (strobe)
  );

  skip_stage_chain #(
    .DATA_W     (DATA_W),
    .NUM_STAGES (NUM_STAGES)
  ) uChain (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inValid  (inValid),
    .inData   (inData),
    .outValid (outValid),
    .outData  (outData)
  );

endmodule

// File: rtl/skip_pipe_chk.sv
module skip_pipe_chk #(
  parameter int NUM_STAGES = 4
) (
  input logic clk,
  input logic rstN,
  input logic halfMode,
  input logic inValid,
  input logic outValid
);

  localparam logic [15:0] FULL_LAT = 16'(NUM_STAGES);
  localparam logic [15:0] HALF_LAT = 16'(NUM_STAGES / 2);

  logic [31:0] inCnt;
  logic [31:0] outCnt;
  logic [15:0] idleCnt;
  logic [15:0] curLat;

  assign curLat = halfMode ? HALF_LAT : FULL_LAT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCnt   <= '0;
      outCnt  <= '0;
      idleCnt <= 16'hFFFF;
    end else begin
      inCnt   <= inCnt + {31'b0, inValid};
      outCnt  <= outCnt + {31'b0, outValid};
      if (inValid)                idleCnt <= '0;
      else if (idleCnt != 16'hFFFF) idleCnt <= idleCnt + 16'd1;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rstN |=> !outValid);

  // R4
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outCnt < inCnt));

  // R2 R3
  drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idleCnt >= curLat) |-> !outValid);

  // R3
  no_flowthrough_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (inCnt == outCnt)) |-> !outValid);

  // R6
  mode_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(halfMode) |-> (inCnt == outCnt));

endmodule

bind skip_pipe skip_pipe_chk #(.NUM_STAGES(NUM_STAGES)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .halfMode (halfMode),
  .inValid  (inValid),
  .outValid (outValid)
);

// File: tb/sim_skip_pipe.sv
`timescale 1ns/1ps
module sim_skip_pipe;

  localparam int DATA_W     = 16;
  localparam int NUM_STAGES = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              halfMode = 1'b0;
  logic              inValid = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic              outValid;
  logic [DATA_W-1:0] outData;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  string curTag = "R1";

  logic              histValid [256];
  logic [DATA_W-1:0] histData  [256];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  skip_pipe #(.DATA_W(DATA_W), .NUM_STAGES(NUM_STAGES)) u0 (
    .clk(clk), .rstN(rstN), .halfMode(halfMode),
    .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  // Compare outputs with the input history, then drive the next input.
  task automatic step(input logic v, input logic [DATA_W-1:0] d);
    int lat;
    logic expV;
    logic [DATA_W-1:0] expD;
    @(negedge clk);
    lat  = halfMode ? NUM_STAGES / 2 : NUM_STAGES;
    expV = 1'b0;
    expD = '0;
    if (rstN && cyc >= lat) begin
      expV = histValid[(cyc - lat) % 256];
      expD = histData[(cyc - lat) % 256];
    end
    checks++;
    if (outValid !== expV) begin
      fails++;
      $display("FAIL %s cycle %0d: outValid=%0b expected %0b", curTag, cyc, outValid, expV);
    end else if (expV) begin
      checks++;
      if (outData !== expD) begin
        fails++;
        $display("FAIL %s cycle %0d: outData=%h expected %h", curTag, cyc, outData, expD);
      end
    end
    inValid = v;
    inData  = d;
    histValid[cyc % 256] = rstN ? v : 1'b0;
    histData[cyc % 256]  = d;
  endtask

  task automatic drain();
    for (int i = 0; i < NUM_STAGES + 2; i++) step(1'b0, DATA_W'($urandom));
  endtask

  task automatic runPatterns(input string latTag);
    curTag = latTag;                       // lone word: R2 or R3
    step(1'b1, 16'hA5C3);
    drain();
    curTag = "R5";                         // back-to-back burst
    for (int i = 0; i < 20; i++) step(1'b1, DATA_W'($urandom));
    drain();
    curTag = "R4";                         // alternating bubbles
    for (int i = 0; i < 16; i++) step(i[0], DATA_W'($urandom));
    drain();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      histValid[i] = 1'b0;
      histData[i]  = '0;
    end
    curTag = "R1";
    for (int i = 0; i < 4; i++) step(1'b0, DATA_W'($urandom));
    rstN = 1'b1;
    step(1'b0, '0);
    step(1'b0, '0);

    runPatterns("R2");

    @(negedge clk);
    halfMode = 1'b1;                       // R6: switch on empty chain
    curTag = "R6";
    step(1'b1, 16'h1234);
    drain();
    runPatterns("R3");

    @(negedge clk);
    halfMode = 1'b0;                       // R6: switch back
    curTag = "R6";
    step(1'b1, 16'h5678);
    step(1'b1, 16'h9ABC);
    drain();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule